// File: doc/BRIEF.md
# BCD Stopwatch with Lap Capture

This block is a millisecond stopwatch for a small control chip. Three cascaded BCD digits hold the elapsed time in thousandths, hundredths and tenths of a second. They advance on a 1000 Hz enable pulse while the stopwatch runs. Software never reads the live counter directly. It reads a capture buffer one nibble at a time, lowest digit first, so the three nibbles always belong to the same instant.

Two push keys control the stopwatch directly. The run key toggles between running and stopped. The lap key freezes the current time in the capture buffer, and the buffer then holds that value until software finishes reading it. The keys are synchronised to the system clock and sampled only on a 1024 Hz sample enable. A key release is accepted only after a long enough run of low samples, so chatter is rejected.

The block raises interrupt flags for the 10 Hz and 1 Hz carries, for each key action, for a renewed capture, and for a 1 Hz carry that falls while a lap value is held. Each flag stays set until software writes a 1 to it.

Top module: `bcd_lap_stopwatch`

## Requirements
- R1: The count is three BCD digits: low = 1/1000 s, mid = 1/100 s, high = 1/10 s. While running, each `tick1k` pulse adds one. A digit at 9 rolls to 0 and carries into the next digit, and 999 wraps to 000.
- R2: Flag bit 0 (10 Hz) is set when the mid digit rolls from 9 to 0. Flag bit 1 (1 Hz) is set when the high digit rolls from 9 to 0. Both flags are set unconditionally; there is no mask.
- R3: A 1 in bit n of `flagClr` clears flag bit n. If a flag is set and cleared in the same cycle, the set wins. The flag bits are: 0 10 Hz, 1 1 Hz, 2 run key, 3 lap key, 4 capture renewal, 5 lap carry-up request.
- R4: A read strobe with `rdSel`=0 returns the low digit. If no hold is active, it also loads the whole buffer from the live count and returns the live low digit. `rdSel`=1 returns the buffered mid digit and `rdSel`=2 returns the buffered high digit.
- R5: An accepted lap key press loads the buffer from the live count, sets the hold, and sets flag bits 3 and 4. While the hold is active, a low-digit read does not reload the buffer. A read with `rdSel`=2 releases the hold.
- R6: A 1 Hz carry that occurs while the hold is active sets flag bit 5.
- R7: A `cntRst` pulse clears the count, and it wins over a coincident tick. It leaves the capture buffer unchanged.
- R8: A `runWr` pulse sets the running state to `runVal`. While stopped, the count keeps its value, and counting resumes from that value. A `runWr` pulse overrides a run key toggle in the same cycle.
- R9: The synchronised keys are sampled only on `tick1024`. An accepted run key press toggles `running` and sets flag bit 2.
- R10: After a press is accepted, a new press is accepted only after DEB_TICKS consecutive low samples (default 48, about 47 ms). A high sample before that restarts the wait and produces no action.
- R11: If run and lap presses are accepted on the same sample, both actions take effect.
- R12: After reset, the count, buffer, hold, running state and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick1k | input | 1 | 1000 Hz count enable, one clock wide |
| tick1024 | input | 1 | 1024 Hz key sample enable, one clock wide |
| runKey | input | 1 | Raw run/stop key, high when pressed |
| lapKey | input | 1 | Raw lap key, high when pressed |
| runWr | input | 1 | Software write strobe for the running state |
| runVal | input | 1 | Running state written by `runWr` |
| cntRst | input | 1 | Software counter clear strobe |
| rdStb | input | 1 | Software read strobe for a capture nibble |
| rdSel | input | 2 | Digit select: 0 low, 1 mid, 2 high |
| flagClr | input | 6 | Write-one-to-clear for the flags |
| rdNibble | output | 4 | Selected BCD digit |
| running | output | 1 | Stopwatch running state |
| flags | output | 6 | Interrupt flags |

## Verification
A counter carry and a software clear of the same flag can fall on one clock edge. The bench provokes this by driving `tick1k` on the step from 999 to 000 together with the clear bit for the 1 Hz flag, and it passes only if the flag reads 1 afterwards. A counter clear and a count tick can also coincide: both are driven in one cycle, and the count must read 000 while the buffer keeps its old digits. Run and lap presses that arrive on the same sample are judged by `running` toggling and both key flags being set.

// File: rtl/sw_pkg.sv
package sw_pkg;

  localparam int DIGIT_W = 4;
  localparam int FLAG_W  = 6;

  localparam int FLG_10HZ  = 0;
  localparam int FLG_1HZ   = 1;
  localparam int FLG_RUNK  = 2;
  localparam int FLG_LAPK  = 3;
  localparam int FLG_RENEW = 4;
  localparam int FLG_LCUR  = 5;

  typedef struct packed {
    logic stepEn;   // advance the count by one
    logic cntClr;   // clear the count
    logic capLoad;  // load capture buffer from live count
    logic rdLive;   // low-digit read returns live digit
  } swCtrl_t;

  typedef enum logic [1:0] {
    DB_IDLE    = 2'd0,
    DB_PRESSED = 2'd1,
    DB_SETTLE  = 2'd2
  } dbState_t;

endpackage

// File: rtl/sw_key_debounce.sv
module sw_key_debounce #(
  parameter int DEB_TICKS   = 48,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sampleEn,
  input  logic keyRaw,
  output logic pressPulse
);
  import sw_pkg::*;

  localparam int CNT_W = $clog2(DEB_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST_LOW = CNT_W'(DEB_TICKS - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic keySync;
  dbState_t stateQ, stateD;
  logic [CNT_W-1:0] lowCntQ, lowCntD;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= keyRaw;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], keyRaw};
      end
    end
  endgenerate

  assign keySync = syncQ[SYNC_STAGES-1];

  always_comb begin
    stateD     = stateQ;
    lowCntD    = lowCntQ;
    pressPulse = 1'b0;
    if (sampleEn) begin
      unique case (stateQ)
        DB_IDLE: begin
          if (keySync) begin
            pressPulse = 1'b1;
            stateD     = DB_PRESSED;
          end
        end
        DB_PRESSED: begin
          if (!keySync) begin
            stateD  = DB_SETTLE;
            lowCntD = CNT_W'(1);
          end
        end
        DB_SETTLE: begin
          if (keySync) begin
            stateD  = DB_PRESSED;
            lowCntD = '0;
          end else if (lowCntQ >= LAST_LOW) begin
            stateD  = DB_IDLE;
            lowCntD = '0;
          end else begin
            lowCntD = lowCntQ + CNT_W'(1);
          end
        end
        default: begin
          stateD  = DB_IDLE;
          lowCntD = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= DB_IDLE;
      lowCntQ <= '0;
    end else begin
      stateQ  <= stateD;
      lowCntQ <= lowCntD;
    end
  end

endmodule

// File: rtl/sw_datapath.sv
module sw_datapath #(
  parameter int NUM_DIGITS = 3
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  sw_pkg::swCtrl_t                     ctrl,
  input  logic [1:0]                          rdSel,
  output logic [NUM_DIGITS-1:0]               wrapEv,
  output logic [NUM_DIGITS*sw_pkg::DIGIT_W-1:0] liveCount,
  output logic [NUM_DIGITS*sw_pkg::DIGIT_W-1:0] capBuf,
  output logic [sw_pkg::DIGIT_W-1:0]          rdNibble
);
  import sw_pkg::*;

  localparam logic [DIGIT_W-1:0] NINE = DIGIT_W'(9);

  logic [DIGIT_W-1:0] digitQ [NUM_DIGITS];
  logic [DIGIT_W-1:0] bufQ   [NUM_DIGITS];
  logic [NUM_DIGITS-1:0] carryIn;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_DIGITS; gi++) begin : g_digit
      if (gi == 0) begin : g_first
        assign carryIn[gi] = ctrl.stepEn;
      end else begin : g_next
        assign carryIn[gi] = carryIn[gi-1] && (digitQ[gi-1] == NINE);
      end

      assign wrapEv[gi] = carryIn[gi] && (digitQ[gi] == NINE);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          digitQ[gi] <= '0;
        end else if (ctrl.cntClr) begin
          digitQ[gi] <= '0;
        end else if (carryIn[gi]) begin
          digitQ[gi] <= (digitQ[gi] == NINE) ? '0 : digitQ[gi] + DIGIT_W'(1);
        end
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             bufQ[gi] <= '0;
        else if (ctrl.capLoad) bufQ[gi] <= digitQ[gi];
      end

      assign liveCount[gi*DIGIT_W +: DIGIT_W] = digitQ[gi];
      assign capBuf[gi*DIGIT_W +: DIGIT_W]    = bufQ[gi];
    end
  endgenerate

  always_comb begin
    rdNibble = '0;
    if (rdSel == 2'd0 && ctrl.rdLive) begin
      rdNibble = digitQ[0];
    end else if (32'(rdSel) < NUM_DIGITS) begin
      rdNibble = bufQ[rdSel];
    end
  end

endmodule

// File: rtl/sw_control.sv
module sw_control #(
  parameter int NUM_DIGITS  = 3,
  parameter int DEB_TICKS   = 48,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       tick1k,
  input  logic                       tick1024,
  input  logic                       runKey,
  input  logic                       lapKey,
  input  logic                       runWr,
  input  logic                       runVal,
  input  logic                       cntRst,
  input  logic                       rdStb,
  input  logic [1:0]                 rdSel,
  input  logic [sw_pkg::FLAG_W-1:0]  flagClr,
  input  logic [NUM_DIGITS-1:0]      wrapEv,
  output sw_pkg::swCtrl_t            ctrl,
  output logic                       running,
  output logic                       holdQ,
  output logic                       lapPress,
  output logic [sw_pkg::FLAG_W-1:0]  flags
);
  import sw_pkg::*;

  localparam int NUM_KEYS = 2;

  logic [NUM_KEYS-1:0] keyRaw;
  logic [NUM_KEYS-1:0] keyPress;
  logic runPress;
  logic runQ;
  logic [FLAG_W-1:0] flagQ, flagSet;
  logic rdLowLoad, rdHighRel;

  assign keyRaw = {lapKey, runKey};

  genvar gk;
  generate
    for (gk = 0; gk < NUM_KEYS; gk++) begin : g_key
      sw_key_debounce #(
        .DEB_TICKS  (DEB_TICKS),
        .SYNC_STAGES(SYNC_STAGES)
      ) deb_i (
        .clk       (clk),
        .rstN      (rstN),
        .sampleEn  (tick1024),
        .keyRaw    (keyRaw[gk]),
        .pressPulse(keyPress[gk])
      );
    end
  endgenerate

  assign runPress = keyPress[0];
  assign lapPress = keyPress[1];

  assign rdLowLoad = rdStb && (rdSel == 2'd0) && !holdQ;
  assign rdHighRel = rdStb && (rdSel == 2'd2);

  always_comb begin
    ctrl.stepEn  = tick1k && runQ && !cntRst;
    ctrl.cntClr  = cntRst;
    ctrl.capLoad = lapPress || rdLowLoad;
    ctrl.rdLive  = !holdQ;
  end

  always_comb begin
    flagSet            = '0;
    flagSet[FLG_10HZ]  = wrapEv[1];
    flagSet[FLG_1HZ]   = wrapEv[NUM_DIGITS-1];
    flagSet[FLG_RUNK]  = runPress;
    flagSet[FLG_LAPK]  = lapPress;
    flagSet[FLG_RENEW] = lapPress;
    flagSet[FLG_LCUR]  = wrapEv[NUM_DIGITS-1] && holdQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      holdQ <= 1'b0;
      flagQ <= '0;
    end else begin
      if (runWr)         runQ <= runVal;
      else if (runPress) runQ <= !runQ;

      if (lapPress)       holdQ <= 1'b1;
      else if (rdHighRel) holdQ <= 1'b0;

      flagQ <= (flagQ & ~flagClr) | flagSet;
    end
  end

  assign running = runQ;
  assign flags   = flagQ;

endmodule

// File: rtl/bcd_lap_stopwatch.sv
module bcd_lap_stopwatch #(
  parameter int NUM_DIGITS  = 3,
  parameter int DEB_TICKS   = 48,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick1k,
  input  logic       tick1024,
  input  logic       runKey,
  input  logic       lapKey,
  input  logic       runWr,
  input  logic       runVal,
  input  logic       cntRst,
  input  logic       rdStb,
  input  logic [1:0] rdSel,
  input  logic [5:0] flagClr,
  output logic [3:0] rdNibble,
  output logic       running,
  output logic [5:0] flags
);
  import sw_pkg::*;

  localparam int CNT_W = NUM_DIGITS * DIGIT_W;

  swCtrl_t ctrlS;
  logic [NUM_DIGITS-1:0] wrapEv;
  logic [CNT_W-1:0] liveCount;
  logic [CNT_W-1:0] capBuf;
  logic holdQ;
  logic lapPress;

  sw_control #(
    .NUM_DIGITS (NUM_DIGITS),
    .DEB_TICKS  (DEB_TICKS),
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .tick1k  (tick1k),
    .tick1024(tick1024),
    .runKey  (runKey),
    .lapKey  (lapKey),
    .runWr   (runWr),
    .runVal  (runVal),
    .cntRst  (cntRst),
    .rdStb   (rdStb),
    .rdSel   (rdSel),
    .flagClr (flagClr),
    .wrapEv  (wrapEv),
    .ctrl    (ctrlS),
    .running (running),
    .holdQ   (holdQ),
    .lapPress(lapPress),
    .flags   (flags)
  );

  sw_datapath #(
    .NUM_DIGITS(NUM_DIGITS)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrlS),
    .rdSel    (rdSel),
    .wrapEv   (wrapEv),
    .liveCount(liveCount),
    .capBuf   (capBuf),
    .rdNibble (rdNibble)
  );

endmodule

// File: rtl/bcd_lap_stopwatch_chk.sv
module bcd_lap_stopwatch_chk (
  input logic        clk,
  input logic        rstN,
  input logic        tick1k,
  input logic        cntRst,
  input logic        running,
  input logic        holdQ,
  input logic        lapPress,
  input logic [11:0] liveCount,
  input logic [11:0] capBuf,
  input logic [5:0]  flags
);

  p_bcd_digits_r1: assert property (@(posedge clk) disable iff (!rstN)
    (liveCount[3:0] <= 4'd9) && (liveCount[7:4] <= 4'd9) && (liveCount[11:8] <= 4'd9));

  p_clear_count_r7: assert property (@(posedge clk) disable iff (!rstN)
    cntRst |=> (liveCount == 12'h000));

  p_stopped_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !cntRst) |=> $stable(liveCount));

  p_wrap_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tick1k && running && !cntRst && liveCount == 12'h999) |=> (flags[1] && liveCount == 12'h000));

  p_lap_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    lapPress |=> (holdQ && flags[4] && flags[3]));

  p_held_buffer_r4: assert property (@(posedge clk) disable iff (!rstN)
    (holdQ && !lapPress) |=> $stable(capBuf));

  p_carry_request_r6: assert property (@(posedge clk) disable iff (!rstN)
    (holdQ && tick1k && running && !cntRst && liveCount == 12'h999) |=> flags[5]);

endmodule

bind bcd_lap_stopwatch bcd_lap_stopwatch_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .tick1k   (tick1k),
  .cntRst   (cntRst),
  .running  (running),
  .holdQ    (holdQ),
  .lapPress (lapPress),
  .liveCount(liveCount),
  .capBuf   (capBuf),
  .flags    (flags)
);

// File: tb/bcd_lap_stopwatch_tb_top.sv
`timescale 1ns/1ps
module bcd_lap_stopwatch_tb_top;

  localparam int DEB = 48;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick1k = 1'b0, tick1024 = 1'b0;
  logic runKey = 1'b0, lapKey = 1'b0;
  logic runWr = 1'b0, runVal = 1'b0, cntRst = 1'b0, rdStb = 1'b0;
  logic [1:0] rdSel = 2'd0;
  logic [5:0] flagClr = 6'd0;
  logic [3:0] rdNibble;
  logic running;
  logic [5:0] flags;

  int total = 0;
  int bad = 0;
  int expCount = 0;
  logic expRun = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bcd_lap_stopwatch dut_i (
    .clk(clk), .rstN(rstN), .tick1k(tick1k), .tick1024(tick1024),
    .runKey(runKey), .lapKey(lapKey), .runWr(runWr), .runVal(runVal),
    .cntRst(cntRst), .rdStb(rdStb), .rdSel(rdSel), .flagClr(flagClr),
    .rdNibble(rdNibble), .running(running), .flags(flags)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick1k = 1'b1;
      @(negedge clk) tick1k = 1'b0;
      if (expRun) expCount = (expCount + 1) % 1000;
    end
  endtask

  task automatic readSel(input logic [1:0] s, output int v);
    @(negedge clk) begin rdStb = 1'b1; rdSel = s; end
    #1 v = int'(rdNibble);
    @(negedge clk) begin rdStb = 1'b0; rdSel = 2'd0; end
  endtask

  task automatic readAll(output int val);
    int lo, mid, hi;
    readSel(2'd0, lo);
    readSel(2'd1, mid);
    readSel(2'd2, hi);
    val = hi * 100 + mid * 10 + lo;
  endtask

  task automatic swRun(input logic v);
    @(negedge clk) begin runWr = 1'b1; runVal = v; end
    @(negedge clk) runWr = 1'b0;
    expRun = v;
  endtask

  task automatic clrFlags(input logic [5:0] m);
    @(negedge clk) flagClr = m;
    @(negedge clk) flagClr = 6'd0;
  endtask

  task automatic cntClear();
    @(negedge clk) cntRst = 1'b1;
    @(negedge clk) cntRst = 1'b0;
    expCount = 0;
  endtask

  task automatic keyTicks(input logic r, input logic l, input int n);
    @(negedge clk) begin runKey = r; lapKey = l; end
    repeat (3) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick1024 = 1'b1;
      @(negedge clk) tick1024 = 1'b0;
    end
  endtask

  task automatic pressKeys(input logic r, input logic l);
    keyTicks(r, l, 1);
    keyTicks(1'b0, 1'b0, DEB);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R12 flags after reset", int'(flags), 0);
    chk("R12 running after reset", int'(running), 0);
    chk("R12 live low digit after reset", int'(rdNibble), 0);
  endtask

  task automatic t_count();
    int v;
    swRun(1'b1);
    step(7);
    readAll(v);
    chk("R8 count after run", v, 7);
    step(5);
    readAll(v);
    chk("R1 carry low to mid", v, 12);
  endtask

  task automatic t_stop();
    int v;
    swRun(1'b0);
    step(4);
    readAll(v);
    chk("R8 stopped count kept", v, 12);
    swRun(1'b1);
    step(3);
    readAll(v);
    chk("R8 resumes from held value", v, 15);
  endtask

  task automatic t_flags();
    int v;
    cntClear();
    clrFlags(6'h3f);
    step(99);
    chk("R2 no 10Hz before rollover", int'(flags[0]), 0);
    step(1);
    chk("R2 10Hz flag at 099->100", int'(flags[0]), 1);
    chk("R2 no 1Hz at 099->100", int'(flags[1]), 0);
    step(899);
    clrFlags(6'h3f);
    step(1);
    chk("R2 1Hz flag at wrap", int'(flags[1]), 1);
    chk("R2 10Hz flag at wrap", int'(flags[0]), 1);
    chk("R6 no carry request without hold", int'(flags[5]), 0);
    readAll(v);
    chk("R1 999 wraps to 000", v, 0);
    clrFlags(6'h01);
    chk("R3 cleared bit0", int'(flags[0]), 0);
    chk("R3 other bit kept", int'(flags[1]), 1);
    step(999);
    clrFlags(6'h3f);
    @(negedge clk) begin tick1k = 1'b1; flagClr = 6'h02; end
    @(negedge clk) begin tick1k = 1'b0; flagClr = 6'h00; end
    expCount = 0;
    chk("R3 set wins over clear", int'(flags[1]), 1);
  endtask

  task automatic t_cnt_reset();
    int v;
    step(345);
    readAll(v);
    chk("R1 count before clear", v, 345);
    @(negedge clk) begin cntRst = 1'b1; tick1k = 1'b1; end
    @(negedge clk) begin cntRst = 1'b0; tick1k = 1'b0; end
    expCount = 0;
    readSel(2'd1, v);
    chk("R7 buffer mid kept after clear", v, 4);
    readSel(2'd2, v);
    chk("R7 buffer high kept after clear", v, 3);
    readAll(v);
    chk("R7 clear wins over tick", v, 0);
  endtask

  task automatic t_lap();
    int v;
    step(256);
    clrFlags(6'h3f);
    pressKeys(1'b0, 1'b1);
    chk("R5 lap flag", int'(flags[3]), 1);
    chk("R5 renewal flag", int'(flags[4]), 1);
    chk("R5 lap leaves running", int'(running), 1);
    step(20);
    readAll(v);
    chk("R5 held lap value", v, 256);
    readAll(v);
    chk("R4 live after hold released", v, 276);
  endtask

  task automatic t_carry_req();
    int v;
    clrFlags(6'h3f);
    pressKeys(1'b0, 1'b1);
    step(1000 - expCount);
    chk("R6 carry request while held", int'(flags[5]), 1);
    readAll(v);
    chk("R5 lap value still held", v, 276);
  endtask

  task automatic t_runkey();
    clrFlags(6'h3f);
    @(negedge clk) runKey = 1'b1;
    repeat (10) @(negedge clk);
    chk("R9 no toggle without sample", int'(running), 1);
    keyTicks(1'b1, 1'b0, 1);
    expRun = 1'b0;
    chk("R9 run key toggles", int'(running), 0);
    chk("R9 run key flag", int'(flags[2]), 1);
    keyTicks(1'b0, 1'b0, DEB);
  endtask

  task automatic t_chatter();
    keyTicks(1'b1, 1'b0, 1);
    chk("R10 first press", int'(running), 1);
    keyTicks(1'b0, 1'b0, 10);
    keyTicks(1'b1, 1'b0, 1);
    chk("R10 chatter ignored", int'(running), 1);
    keyTicks(1'b0, 1'b0, DEB - 1);
    keyTicks(1'b1, 1'b0, 1);
    chk("R10 short release ignored", int'(running), 1);
    keyTicks(1'b0, 1'b0, DEB);
    keyTicks(1'b1, 1'b0, 1);
    chk("R10 press after full release", int'(running), 0);
    keyTicks(1'b0, 1'b0, DEB);
    expRun = 1'b0;
  endtask

  task automatic t_both();
    clrFlags(6'h3f);
    pressKeys(1'b1, 1'b1);
    expRun = 1'b1;
    chk("R11 run toggled", int'(running), 1);
    chk("R11 run flag", int'(flags[2]), 1);
    chk("R11 lap flag", int'(flags[3]), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_count();
    t_stop();
    t_flags();
    t_cnt_reset();
    t_lap();
    t_carry_req();
    t_runkey();
    t_chatter();
    t_both();
    finished = 1'b1;
  end

  initial begin
    fork
      begin
        wait (finished);
      end
      begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule